// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block holds the synchronous address and control logic of a pipelined burst SRAM, together with a small internal array built from one memory per data lane. Every control input except the output enable is taken on the rising clock edge. A cycle can do one of several things. It can load a new external address. It can continue the current burst, either stepping the low two address bits or holding them to make a wait state. It can write any mix of the four 9-bit lanes of a 36-bit word, or it can read.

Read data passes through two registers: the array's registered read and then an output register. The output enable acts asynchronously on the final drive. High impedance is shown as `dq_drive` low, and while it is low `q_out` is held at zero.

Top module: `sbsram_front`

## Requirements
- R1: A load cycle is a rising edge with `ads_n` low and `ce_n` low. It registers `sa` as the burst address and reads that word. The data appears on `q_out`, with `dq_drive` high, after the second rising edge counted from the load edge.
- R2: A load cycle is always a read. It writes nothing, whatever `gw_n`, `bwe_n` and `bw_n` are.
- R3: When `ce_n` is high, `ads_n` low has no effect. The edge is handled as a burst continuation and the burst address is not reloaded from `sa`.
- R4: A load cycle with `ce_hi` low or `ce_lo_n` high deselects the block. Until the next selected load, no cycle reads or writes, and no data is driven for that load.
- R5: `ce_hi` and `ce_lo_n` are sampled only on load cycles. Changing them during a burst has no effect.
- R6: On a continuation cycle with `adv_n` low, the low two address bits step in the order 00, 01, 10, 11, 00. The upper bits stay fixed, and the cycle uses the stepped address.
- R7: On a continuation cycle with `adv_n` high, the address holds and the cycle uses the same address again (a wait state).
- R8: On a selected continuation cycle, `gw_n` low writes all four lanes of `d_in`, whatever `bwe_n` and `bw_n` are.
- R9: When `gw_n` is high and `bwe_n` is low, lane i (`d_in` bits 9i+8 down to 9i) is written if and only if `bw_n[i]` is low. If no lane is enabled, the cycle is a read.
- R10: When `gw_n` and `bwe_n` are both high, a selected continuation cycle is a read, whatever `bw_n` is.
- R11: `dq_drive` equals "registered read data valid" AND NOT `oe_n`, and it follows `oe_n` without waiting for a clock. `q_out` is zero whenever `dq_drive` is low.
- R12: A synchronous active-high reset `rst` deselects the block and clears the read pipeline, so nothing is driven after it.
- R13: A selected load in the middle of a burst aborts that burst at once and starts a new one from `sa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sa | input | ADDR_W | External word address |
| ce_n | input | 1 | Primary chip enable, active low; qualifies `ads_n` |
| ce_hi | input | 1 | Chip enable, active high, sampled on loads |
| ce_lo_n | input | 1 | Secondary chip enable, active low, sampled on loads |
| ads_n | input | 1 | Address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| gw_n | input | 1 | Global (full-word) write, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data |
| dq_drive | output | 1 | High when the output is driven |
| q_out | output | LANES*LANE_W | Read data, zero when not driven |

## Verification
The hardest case is a write that follows a load while `adv_n` is low, where the write must land on the stepped address and not on the loaded one. Close behind it is a write that stays disabled after a deselecting load, while the chip-enable inputs move around during what would otherwise be a burst. The stimulus reaches both in two ways: directed sequences that follow a load with continuation writes, and a random phase with rare strobes that mixes advance, wait and enable patterns. A behavioural model tracks the burst address, a per-lane known mask and the two-stage read pipeline, and both outputs are compared against it on every clock.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int unsigned BURST_BITS = 2;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sbsram_addr_ctl.sv
module sbsram_addr_ctl
  import sbsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sa,
  input  logic              ce_n,
  input  logic              ce_hi,
  input  logic              ce_lo_n,
  input  logic              ads_n,
  input  logic              adv_n,
  output logic              load,
  output logic              live,
  output logic              active,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic              sel;
  logic [ADDR_W-1:0] step_addr;

  assign load = ~rst & ~ads_n & ~ce_n;
  assign sel  = ce_hi & ~ce_lo_n;

  // only the low burst bits move; they wrap linearly
  assign step_addr = {burst_addr[ADDR_W-1:BURST_BITS],
                      burst_addr[BURST_BITS-1:0] + {{(BURST_BITS-1){1'b0}}, 1'b1}};

  always_comb begin
    if (load)        cyc_addr = sa;
    else if (!adv_n) cyc_addr = step_addr;
    else             cyc_addr = burst_addr;
  end

  assign live = ~rst & (load ? sel : active);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      burst_addr <= '0;
    end else if (load) begin
      active     <= sel;
      burst_addr <= sa;
    end else if (active) begin
      burst_addr <= cyc_addr;
    end
  end
endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             live,
  input  logic             load,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en
);
  logic wr_ok;
  assign wr_ok = live & ~load;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_ok & (~gw_n | (~bwe_n & ~bw_n[i]));
  end

  assign rd_en = live & (load | (lane_we == '0));
endmodule

// File: rtl/sbsram_lane_ram.sv
module sbsram_lane_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rq
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rq <= mem[addr];
  end
endmodule

// File: rtl/sbsram_front.sv
module sbsram_front #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         sa,
  input  logic                      ce_n,
  input  logic                      ce_hi,
  input  logic                      ce_lo_n,
  input  logic                      ads_n,
  input  logic                      adv_n,
  input  logic                      bwe_n,
  input  logic                      gw_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   d_in,
  output logic                      dq_drive,
  output logic [LANES*LANE_W-1:0]   q_out
);
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic              load, live, active, rd_en;
  logic [ADDR_W-1:0] burst_addr, cyc_addr;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rq_word, q_reg;
  logic              rd_v, q_v;

  sbsram_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .sa(sa), .ce_n(ce_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .ads_n(ads_n), .adv_n(adv_n), .load(load),
    .live(live), .active(active), .burst_addr(burst_addr),
    .cyc_addr(cyc_addr)
  );

  sbsram_wr_decode #(.LANES(LANES)) u_dec (
    .live(live), .load(load), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .rd_en(rd_en)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_ram
    sbsram_lane_ram #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_ram (
      .clk(clk), .we(lane_we[i]), .addr(cyc_addr),
      .wd(d_in[i*LANE_W +: LANE_W]), .rq(rq_word[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0;
      q_v  <= 1'b0;
    end else begin
      rd_v <= rd_en;
      q_v  <= rd_v;
    end
  end

  always_ff @(posedge clk) q_reg <= rq_word;

  assign dq_drive = q_v & ~oe_n;
  assign q_out    = dq_drive ? q_reg : '0;
endmodule

// File: rtl/sbsram_front_chk.sv
module sbsram_front_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ads_n,
  input logic              ce_n,
  input logic              ce_hi,
  input logic              ce_lo_n,
  input logic              adv_n,
  input logic              gw_n,
  input logic              dq_drive,
  input logic              active,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [LANES-1:0]  lane_we
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_drive); // R12

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && !ce_n) |-> (lane_we == '0)); // R2

  AST_DESELECT_DARK: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && !ce_n && !(ce_hi && !ce_lo_n)) |-> ##2 !dq_drive); // R4

  AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && ce_n && adv_n) |=> (burst_addr == $past(burst_addr))); // R3

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ads_n && adv_n) |=> $stable(burst_addr)); // R7

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!(!ads_n && !ce_n) && active && !adv_n) |=>
      (burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1) &&
      (burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]))); // R6

  AST_GW_FULL: assert property (@(posedge clk) disable iff (rst)
    (!(!ads_n && !ce_n) && active && !gw_n) |-> (lane_we == '1)); // R8
endmodule

bind sbsram_front sbsram_front_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .ads_n(ads_n), .ce_n(ce_n), .ce_hi(ce_hi),
  .ce_lo_n(ce_lo_n), .adv_n(adv_n), .gw_n(gw_n), .dq_drive(dq_drive),
  .active(active), .burst_addr(burst_addr), .lane_we(lane_we)
);

// File: tb/sbsram_front_tb.sv
module sbsram_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] sa = '0;
  logic ce_n = 1'b1, ce_hi = 1'b1, ce_lo_n = 1'b0;
  logic ads_n = 1'b1, adv_n = 1'b1, bwe_n = 1'b1, gw_n = 1'b1;
  logic [NL-1:0] bw_n = '1;
  logic oe_n = 1'b0;
  logic [WW-1:0] d_in = '0;
  logic dq_drive;
  logic [WW-1:0] q_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbsram_front #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .sa(sa), .ce_n(ce_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .ads_n(ads_n), .adv_n(adv_n), .bwe_n(bwe_n),
    .gw_n(gw_n), .bw_n(bw_n), .oe_n(oe_n), .d_in(d_in),
    .dq_drive(dq_drive), .q_out(q_out)
  );

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  string cur_req = "R12";

  // behavioural model
  logic [WW-1:0] mm [256];
  logic [NL-1:0] mk [256];
  bit m_act = 0;
  logic [AW-1:0] m_ba = '0;
  bit m_rdv = 0, m_rdk = 0, m_qv = 0, m_qk = 0;
  logic [WW-1:0] m_rdq = '0, m_q = '0;

  initial for (int i = 0; i < 256; i++) mk[i] = '0;

  task automatic model_read(input logic [AW-1:0] a);
    m_rdv = 1;
    m_rdk = (mk[a] == '1);
    m_rdq = mm[a];
  endtask

  task automatic model_step();
    logic [AW-1:0] a;
    logic [NL-1:0] mask;
    m_qv = m_rdv; m_q = m_rdq; m_qk = m_rdk;
    m_rdv = 0;
    if (rst) begin
      m_act = 0; m_ba = '0; m_qv = 0;
      return;
    end
    if (!ads_n && !ce_n) begin
      m_ba = sa;
      m_act = ce_hi && !ce_lo_n;
      if (m_act) model_read(sa);
    end else if (m_act) begin
      a = adv_n ? m_ba : {m_ba[AW-1:2], m_ba[1:0] + 2'd1};
      m_ba = a;
      for (int i = 0; i < NL; i++) mask[i] = !gw_n || (!bwe_n && !bw_n[i]);
      if (mask != 0) begin
        for (int i = 0; i < NL; i++)
          if (mask[i]) mm[a][i*LW +: LW] = d_in[i*LW +: LW];
        mk[a] = mk[a] | mask;
      end else model_read(a);
    end
  endtask

  task automatic compare();
    bit ed;
    ed = m_qv && !oe_n;
    n_cmp++;
    if (dq_drive !== ed) begin
      n_bad++;
      $display("FAIL %s dq_drive actual=%0b expected=%0b t=%0t", cur_req, dq_drive, ed, $time);
    end
    if (ed && m_qk) begin
      n_cmp++;
      if (q_out !== m_q) begin
        n_bad++;
        $display("FAIL %s q_out actual=%h expected=%h t=%0t", cur_req, q_out, m_q, $time);
      end
    end else if (!ed) begin
      n_cmp++;
      if (q_out !== '0) begin
        n_bad++;
        $display("FAIL %s q_out actual=%h expected=0 (undriven) t=%0t", cur_req, q_out, $time);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    ads_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1; ce_n = 1;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    quiet(); ce_n = 0; ce_hi = 1; ce_lo_n = 0; ads_n = 0; sa = a; tick();
  endtask

  task automatic cont(input bit adv, input bit gw, input bit bwe,
                      input logic [NL-1:0] bw, input logic [WW-1:0] d);
    quiet(); adv_n = !adv; gw_n = !gw; bwe_n = !bwe; bw_n = bw; d_in = d; tick();
  endtask

  function automatic logic [WW-1:0] pat(input int a, input int s);
    return WW'((a * 36'h1_0203) ^ (s * 36'h9_5A17) ^ 36'h3_C3C3);
  endfunction

  // watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL WDOG watchdog expired actual=%0d expected<150000", n_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset
    cur_req = "R12";
    rst = 1; quiet();
    repeat (3) tick();
    rst = 0;
    tick();

    // R8: fill words with full-word writes; first write uses held address
    cur_req = "R8";
    for (int b = 0; b < 64; b += 4) begin
      do_load(AW'(b));
      cont(0, 1, 1, 4'b0000, pat(b, 1));
      for (int k = 1; k < 4; k++) cont(1, 1, 0, '1, pat(b + k, 1));
    end
    quiet(); repeat (2) tick();

    // R1/R6: read burst starting at low bits 10 wraps 11 -> 00
    cur_req = "R6";
    do_load(AW'(8'h12));
    for (int k = 0; k < 4; k++) cont(1, 0, 0, '1, '0);
    cur_req = "R1";
    quiet(); repeat (2) tick();

    // R7: wait states
    cur_req = "R7";
    do_load(AW'(8'h21));
    cont(0, 0, 1, '1, '0);
    cont(0, 0, 1, '1, '0);
    cont(1, 0, 1, '1, '0);
    cont(0, 0, 1, '1, '0);
    quiet(); repeat (2) tick();

    // R2: load cycle with every write control active stays a read
    cur_req = "R2";
    quiet(); ce_n = 0; ads_n = 0; sa = 8'h08; gw_n = 0; bwe_n = 0; bw_n = '0;
    d_in = 36'hF_FFFF_FFFF; tick();
    quiet(); repeat (2) tick();
    do_load(8'h08); quiet(); repeat (2) tick();

    // R9: lane writes
    cur_req = "R9";
    do_load(8'h30);
    cont(0, 0, 1, 4'b1010, 36'h1_2345_6789);
    cont(1, 0, 1, 4'b0111, 36'hA_BCDE_F012);
    cont(1, 0, 1, 4'b1111, 36'h0);
    do_load(8'h30); cont(1, 0, 0, '1, '0); quiet(); repeat (2) tick();

    // R10: bwe_n high -> read even with bw_n low
    cur_req = "R10";
    do_load(8'h34);
    cont(0, 0, 0, 4'b0000, 36'h5_5555_5555);
    cont(1, 0, 0, 4'b0000, 36'h5_5555_5555);
    quiet(); repeat (2) tick();

    // R3: strobe with ce_n high continues the burst
    cur_req = "R3";
    do_load(8'h14);
    quiet(); ce_n = 1; ads_n = 0; sa = 8'h3C; adv_n = 0; tick();
    quiet(); ce_n = 1; ads_n = 0; sa = 8'h3C; adv_n = 1; tick();
    cont(1, 1, 0, '1, 36'h7_0000_0007);
    do_load(8'h14); cont(1, 0, 0, '1, '0); cont(1, 0, 0, '1, '0);
    quiet(); repeat (2) tick();

    // R4: deselect via ce_hi low, then via ce_lo_n high; writes blocked
    cur_req = "R4";
    quiet(); ce_n = 0; ads_n = 0; sa = 8'h18; ce_hi = 0; tick();
    cont(0, 1, 0, '1, 36'hD_EAD0_BEEF);
    cont(1, 1, 0, '1, 36'hD_EAD0_BEEF);
    quiet(); ce_n = 0; ads_n = 0; sa = 8'h18; ce_hi = 1; ce_lo_n = 1; tick();
    cont(1, 1, 0, '1, 36'hD_EAD0_BEEF);
    ce_lo_n = 0;
    do_load(8'h18); cont(1, 0, 0, '1, '0); cont(1, 0, 0, '1, '0);
    quiet(); repeat (2) tick();

    // R5: chip enables ignored mid-burst
    cur_req = "R5";
    do_load(8'h24);
    quiet(); ce_hi = 0; ce_lo_n = 1; adv_n = 0; tick();
    quiet(); ce_hi = 0; ce_lo_n = 1; adv_n = 0; gw_n = 0; d_in = 36'h2_4242_4242; tick();
    quiet(); ce_hi = 0; adv_n = 0; tick();
    ce_hi = 1; ce_lo_n = 0;
    quiet(); repeat (2) tick();

    // R13: new load aborts a burst
    cur_req = "R13";
    do_load(8'h28);
    cont(1, 0, 0, '1, '0);
    do_load(8'h0E);
    cont(1, 0, 0, '1, '0);
    cont(1, 0, 0, '1, '0);
    quiet(); repeat (2) tick();

    // R11: asynchronous output enable
    cur_req = "R11";
    do_load(8'h05);
    cont(1, 0, 0, '1, '0);
    cont(1, 0, 0, '1, '0);
    oe_n = 1; #1 compare();
    oe_n = 0; #1 compare();
    oe_n = 1; tick(); oe_n = 0; #1 compare();
    quiet(); repeat (2) tick();

    // mixed random traffic
    cur_req = "MIX";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 99);
      quiet();
      ce_n    = ($urandom_range(0, 3) != 0) ? 1'b0 : 1'b1;
      ads_n   = (r < 12) ? 1'b0 : 1'b1;
      ce_hi   = ($urandom_range(0, 7) != 0);
      ce_lo_n = ($urandom_range(0, 7) == 0);
      sa      = AW'($urandom_range(0, 63));
      adv_n   = $urandom_range(0, 1);
      gw_n    = ($urandom_range(0, 5) != 0);
      bwe_n   = $urandom_range(0, 1);
      bw_n    = NL'($urandom_range(0, 15));
      oe_n    = ($urandom_range(0, 9) == 0);
      d_in    = {4'($urandom), 32'($urandom)};
      tick();
    end
    oe_n = 0; quiet(); repeat (3) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule